// File: doc/BRIEF.md
# Reference and Power Shutdown Controller

This block decides when the converter core and the internal voltage reference of a serial-bus sampling converter draw power. The serial bus front end, which is always powered, hands it single-cycle strobes: one when a byte matching the device address has been taken in, and one on the falling clock edge that closes the acknowledge slot of that byte. It also sends a pulse when a conversion finishes and a strobe when the bus master declines a result byte. A level pin says whether an external reference is fitted. From these inputs the block drives three levels: converter enable, reference enable, and a reference-ready flag.

The converter core is powered only for the length of one conversion. The reference behaves in one of two ways. With an external reference fitted, the internal reference is never powered and the direction bit of the address byte plays no part. With the internal reference in use, the direction bit is captured as a keep-alive flag when the address is matched. A flag of 1 keeps the reference powered across transactions. A flag of 0 turns it off at the master's decline that ends the read. After each power-up, a timer counts a parameterised settle period in system clocks before it reports the reference as ready. A conversion that starts earlier than that is to be treated as a throw-away sample.

Every pin is a plain strobe or level. No data passes through the block, so it has no valid/ready stream and no back-pressure.

Top module: `refpwr_ctrl`

## Requirements
- R1: While reset is asserted and on its release, conv_en, ref_en and ref_ready are all 0.
- R2: An addr_hit strobe drives conv_en to 1 on the next clock.
- R3: A conv_done pulse drives conv_en to 0 on the next clock. If addr_hit arrives in the same cycle, conv_en stays 1.
- R4: With ext_ref at 0, an ack_fall strobe drives ref_en to 1 on the next clock, provided an addr_hit came in the same cycle or earlier and has not yet been consumed by an ack_fall.
- R5: While ext_ref is 1, ref_en is 0 from the next clock on, whatever the direction bit is. When ext_ref returns to 0, ref_en stays 0 until the next qualified ack_fall.
- R6: If rw_flag was 1 at the addr_hit, a host_nack leaves ref_en at 1.
- R7: If rw_flag was 0 at the addr_hit, a host_nack that falls between the qualified ack_fall and the end of that transaction drives ref_en to 0 on the next clock.
- R8: ref_ready rises exactly SETTLE_CYCLES clocks after ref_en rises. After any power-down, the count starts again from zero.
- R9: ref_ready is 0 in every cycle in which ref_en is 0, and it falls in the same cycle as ref_en.
- R10: rw_flag is sampled only in the addr_hit cycle. Later changes on it do not affect the transaction.
- R11: An ack_fall with no pending addr_hit does not enable the reference. A host_nack outside a transaction that was opened by a qualified ack_fall does not disable it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on) |
| addr_hit | input | 1 | Strobe: an address byte matching this device was received |
| rw_flag | input | 1 | Direction bit of that address byte, used as the keep-alive flag |
| ack_fall | input | 1 | Strobe: falling clock edge that ends the address acknowledge slot |
| conv_done | input | 1 | Pulse: the current conversion has finished |
| host_nack | input | 1 | Strobe: the master declined a result byte |
| ext_ref | input | 1 | Level: 1 when an external reference is fitted |
| conv_en | output | 1 | Converter core power enable |
| ref_en | output | 1 | Internal reference power enable |
| ref_ready | output | 1 | Internal reference has settled |

## Verification
Each output is a single register stage away from its cause:
- conv_en and ref_en change on the first rising edge after their strobe.
- ref_ready rises SETTLE_CYCLES edges after ref_en rose.
- ref_ready falls on the same edge as ref_en.

The bench changes inputs on the falling edge and holds every strobe for exactly one rising edge. It then reads the outputs on the next falling edge, which is the first point where a one-edge result can be seen. Settle checks count falling edges from the one at which ref_en was first seen high, and they compare ref_ready in every cycle of the window. This catches a ready flag that rises one cycle early or one cycle late.

// File: rtl/rpc_pkg.sv
package rpc_pkg;

  // Default settle period: 12 ms at 100 MHz
  localparam int unsigned DEFAULT_SETTLE = 1_200_000;

  typedef struct packed {
    logic addr_hit;
    logic ack_fall;
    logic host_nack;
    logic conv_done;
  } bus_evt_t;

endpackage

// File: rtl/rpc_session.sv
module rpc_session
  import rpc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  bus_evt_t evt,
  input  logic     rw_flag,
  output logic     wake_ref,
  output logic     drop_ref
);
  logic pending_q;
  logic keep_q;
  logic in_txn_q;
  logic armed;

  assign armed    = pending_q | evt.addr_hit;
  assign wake_ref = evt.ack_fall & armed;
  assign drop_ref = evt.host_nack & in_txn_q & ~keep_q & ~wake_ref;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      keep_q    <= 1'b0;
      in_txn_q  <= 1'b0;
    end else begin
      if (evt.ack_fall)      pending_q <= 1'b0;
      else if (evt.addr_hit) pending_q <= 1'b1;

      if (evt.addr_hit) keep_q <= rw_flag;

      if (wake_ref)           in_txn_q <= 1'b1;
      else if (evt.host_nack) in_txn_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rpc_conv_gate.sv
module rpc_conv_gate
  import rpc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  bus_evt_t evt,
  output logic     conv_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             conv_en <= 1'b0;
    else if (evt.addr_hit)  conv_en <= 1'b1;
    else if (evt.conv_done) conv_en <= 1'b0;
  end
endmodule

// File: rtl/rpc_ref_gate.sv
module rpc_ref_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_ref,
  input  logic wake_ref,
  input  logic drop_ref,
  output logic ref_en_d,
  output logic ref_en
);
  always_comb begin
    if (ext_ref)       ref_en_d = 1'b0;
    else if (wake_ref) ref_en_d = 1'b1;
    else if (drop_ref) ref_en_d = 1'b0;
    else               ref_en_d = ref_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_en <= 1'b0;
    else        ref_en <= ref_en_d;
  end
endmodule

// File: rtl/rpc_settle_timer.sv
module rpc_settle_timer #(
  parameter int unsigned SETTLE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_en_d,
  input  logic ref_en,
  output logic ready
);
  localparam int unsigned CW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CW-1:0] LIM    = CW'(SETTLE_CYCLES);
  localparam logic [CW-1:0] LIM_M1 = CW'(SETTLE_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ready <= 1'b0;
    end else if (!ref_en_d) begin
      cnt_q <= '0;
      ready <= 1'b0;
    end else if (ref_en) begin
      if (cnt_q != LIM)    cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LIM_M1) ready <= 1'b1;
    end
  end
endmodule

// File: rtl/refpwr_ctrl.sv
module refpwr_ctrl
  import rpc_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = DEFAULT_SETTLE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_hit,
  input  logic rw_flag,
  input  logic ack_fall,
  input  logic conv_done,
  input  logic host_nack,
  input  logic ext_ref,
  output logic conv_en,
  output logic ref_en,
  output logic ref_ready
);
  bus_evt_t evt;
  logic     wake_ref;
  logic     drop_ref;
  logic     ref_en_d;

  assign evt = '{addr_hit: addr_hit, ack_fall: ack_fall,
                 host_nack: host_nack, conv_done: conv_done};

  rpc_session u_session (
    .clk(clk), .rst_n(rst_n), .evt(evt), .rw_flag(rw_flag),
    .wake_ref(wake_ref), .drop_ref(drop_ref)
  );

  rpc_conv_gate u_conv (
    .clk(clk), .rst_n(rst_n), .evt(evt), .conv_en(conv_en)
  );

  rpc_ref_gate u_ref (
    .clk(clk), .rst_n(rst_n), .ext_ref(ext_ref), .wake_ref(wake_ref),
    .drop_ref(drop_ref), .ref_en_d(ref_en_d), .ref_en(ref_en)
  );

  rpc_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .ref_en_d(ref_en_d), .ref_en(ref_en),
    .ready(ref_ready)
  );
endmodule

// File: rtl/refpwr_ctrl_chk.sv
module refpwr_ctrl_chk #(
  parameter int unsigned SETTLE_CYCLES = 16
) (
  input logic clk,
  input logic rst_n,
  input logic addr_hit,
  input logic ack_fall,
  input logic conv_done,
  input logic ext_ref,
  input logic conv_en,
  input logic ref_en,
  input logic ref_ready
);
  localparam int unsigned CW = $clog2(SETTLE_CYCLES + 2);
  localparam logic [CW-1:0] LIM = CW'(SETTLE_CYCLES);

  // Run length of ref_en high, saturating just past the settle period
  logic [CW-1:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hi_cnt <= '0;
    else if (!ref_en)    hi_cnt <= '0;
    else if (hi_cnt <= LIM) hi_cnt <= hi_cnt + 1'b1;
  end

  AST_CONV_UP: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hit |=> conv_en); // R2
  AST_CONV_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !addr_hit) |=> !conv_en); // R3
  AST_REF_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fall && !ext_ref && $past(addr_hit) && !$past(ack_fall)) |=> ref_en); // R4
  AST_EXT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ref |=> !ref_en); // R5
  AST_SETTLE_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_ready) |-> (hi_cnt == LIM)); // R8
  AST_READY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_en |-> !ref_ready); // R9
endmodule

bind refpwr_ctrl refpwr_ctrl_chk #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_hit(addr_hit), .ack_fall(ack_fall),
  .conv_done(conv_done), .ext_ref(ext_ref), .conv_en(conv_en),
  .ref_en(ref_en), .ref_ready(ref_ready)
);

// File: tb/refpwr_ctrl_test.sv
module refpwr_ctrl_test;
  localparam int SETTLE = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic addr_hit = 1'b0, rw_flag = 1'b0, ack_fall = 1'b0;
  logic conv_done = 1'b0, host_nack = 1'b0, ext_ref = 1'b0;
  logic conv_en, ref_en, ref_ready;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  refpwr_ctrl #(.SETTLE_CYCLES(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .addr_hit(addr_hit), .rw_flag(rw_flag),
    .ack_fall(ack_fall), .conv_done(conv_done), .host_nack(host_nack),
    .ext_ref(ext_ref), .conv_en(conv_en), .ref_en(ref_en), .ref_ready(ref_ready)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; addr_hit = 0; rw_flag = 0; ack_fall = 0;
    conv_done = 0; host_nack = 0; ext_ref = 0;
    repeat (3) tick();
    chk("R1 conv_en in reset", conv_en, 1'b0);
    chk("R1 ref_en in reset", ref_en, 1'b0);
    rst_n = 1'b1;
    tick();
  endtask

  // open a transaction: address strobe, then acknowledge-closing edge
  task automatic open_txn(input logic rw);
    rw_flag = rw; addr_hit = 1'b1; tick(); addr_hit = 1'b0;
    rw_flag = ~rw;                       // R10: later value must not matter
    ack_fall = 1'b1; tick(); ack_fall = 1'b0;
  endtask

  initial begin
    tick();
    // sweep: reference source x keep-alive flag
    for (int e = 0; e < 2; e++) begin
      for (int r = 0; r < 2; r++) begin
        do_reset();
        chk("R1 conv_en after reset", conv_en, 1'b0);
        chk("R1 ref_en after reset", ref_en, 1'b0);
        chk("R1 ref_ready after reset", ref_ready, 1'b0);
        ext_ref = logic'(e); tick();
        chk("R5 ref off before txn", ref_en, 1'b0);

        rw_flag = logic'(r); addr_hit = 1'b1; tick(); addr_hit = 1'b0;
        rw_flag = logic'(~r[0]);
        chk("R2 conv_en after addr_hit", conv_en, 1'b1);

        ack_fall = 1'b1; tick(); ack_fall = 1'b0;
        chk(e == 0 ? "R4 ref_en after ack" : "R5 ref_en held off", ref_en, logic'(e == 0));

        for (int k = 1; k <= SETTLE; k++) begin
          tick();
          chk("R8 settle window", ref_ready, logic'(k == SETTLE && e == 0));
        end

        conv_done = 1'b1; tick(); conv_done = 1'b0;
        chk("R3 conv_en after done", conv_en, 1'b0);

        host_nack = 1'b1; tick(); host_nack = 1'b0;
        chk(r == 1 ? "R6 R10 ref_en after nack" : "R7 R10 ref_en after nack",
            ref_en, logic'(e == 0 && r == 1));
        chk("R9 ready follows ref", ref_ready, logic'(e == 0 && r == 1));
      end
    end

    // R11: stray acknowledge edge and stray nack
    do_reset();
    ack_fall = 1'b1; tick(); ack_fall = 1'b0;
    chk("R11 ack without address", ref_en, 1'b0);

    // R3: start and done in the same cycle
    addr_hit = 1'b1; tick(); addr_hit = 1'b0;
    addr_hit = 1'b1; conv_done = 1'b1; tick(); addr_hit = 1'b0; conv_done = 1'b0;
    chk("R3 addr_hit wins over done", conv_en, 1'b1);

    // R6 then R11 then R7
    do_reset();
    open_txn(1'b1);
    chk("R4 ref on", ref_en, 1'b1);
    host_nack = 1'b1; tick(); host_nack = 1'b0;
    chk("R6 keep-alive survives nack", ref_en, 1'b1);
    rw_flag = 1'b0; addr_hit = 1'b1; tick(); addr_hit = 1'b0;
    host_nack = 1'b1; tick(); host_nack = 1'b0;
    chk("R11 nack before ack ignored", ref_en, 1'b1);
    ack_fall = 1'b1; tick(); ack_fall = 1'b0;
    host_nack = 1'b1; tick(); host_nack = 1'b0;
    chk("R7 nack shuts reference", ref_en, 1'b0);
    chk("R9 ready low with ref off", ref_ready, 1'b0);

    // R5 external reference appears while powered, then R8 re-arm
    do_reset();
    open_txn(1'b1);
    repeat (SETTLE) tick();
    chk("R8 ready after settle", ref_ready, 1'b1);
    ext_ref = 1'b1; tick();
    chk("R5 ext forces ref off", ref_en, 1'b0);
    chk("R9 ready drops with ref", ref_ready, 1'b0);
    ext_ref = 1'b0; tick();
    chk("R5 ref stays off after ext clears", ref_en, 1'b0);
    open_txn(1'b1);
    repeat (SETTLE - 1) tick();
    chk("R8 restart not early", ref_ready, 1'b0);
    tick();
    chk("R8 restart on time", ref_ready, 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule